// File: doc/BRIEF.md
# Capacitor Weight Measurement Sequencer

This block runs the calibration pass of a two-branch, charge-redistribution converter before normal conversion begins. It measures one high-order capacitor at a time. The positive branch is measured first, then the negative branch, and within each branch the largest capacitor comes first. Each measurement starts with a sample cycle that ties every bottom plate and the tested top plate to common-mode. Next, the capacitor under test goes to the reference, every smaller high-order capacitor goes to ground, and every larger one stays at common-mode. The low-order sub-array, which holds five binary capacitors and one extra capacitor, then digitizes the leftover charge with a six-step successive-approximation search driven by the comparator.

Each 6-bit result is offered on a valid/ready stream tagged with its branch and capacitor index. When the stream handshake completes, the result is also written into a 2×7 result bank, which stays readable through a combinational read port after the pass ends. If the consumer holds ready low, the sequencer holds everything: the stream data and tags stay stable, the plate controls stay frozen and the next measurement does not start. No result is dropped or overwritten. After the fourteenth handshake, a one-cycle end strobe fires, the calibration-active flag drops and the block stays idle until the next reset.

Top module: `cal_mismatch_seq`

## Requirements
- R1: While `rst_i` is high and right after it is released, `cal_active_o` is 1, `top_rst_p_o` is 1, `code_valid_o` and `cal_done_o` are 0, and every bank entry reads 0.
- R2: Fourteen results are produced. The first seven are on the positive branch (`code_branch_o`=0), then seven on the negative branch (1). Within a branch the capacitor index `code_cap_o` runs 0 (largest capacitor) up to 6 (smallest).
- R3: Each measurement starts with one sample cycle. In that cycle every plate control is common-mode (2'b00), the top-plate tie flag of the tested branch is 1, and the other branch's flag is 0.
- R4: From the cycle after the sample cycle until the handshake, the tested branch drives the high-order field m (bits [2m+1:2m], m=0 being the smallest capacitor) as follows: reference (2'b10) for the capacitor under test (m = 6 − index), ground (2'b01) for every m below it, and common-mode for every m above it. All controls of the other branch stay 2'b00.
- R5: The search takes six comparator decisions, one per cycle, starting on the second cycle after the sample cycle, most significant bit first. The k-th decision is code bit 5−k. The low-order field i (bits [2i+1:2i], i=5 for the extra capacitor, 4..0 for the binary ones) holds common-mode until its bit is decided, then goes to ground for a 1 and to reference for a 0.
- R6: On the positive branch a code bit equals `cmp_i` at its decision edge. On the negative branch it equals the inverse of `cmp_i`.
- R7: `code_valid_o` rises the cycle after the sixth decision. While `code_ready_i` is low, valid, data, tags and all plate controls stay unchanged and no new measurement starts.
- R8: A result is written into the bank at the clock edge where valid and ready are both 1. `rd_code_o` returns the entry selected by `rd_branch_i` and `rd_cap_i`.
- R9: The cycle after the final handshake, `cal_done_o` is 1 for exactly one cycle while `cal_active_o` is still 1. From the next cycle on, `cal_active_o` is 0.
- R10: After the pass, every plate control is 2'b00, both tie flags and `code_valid_o` are 0, `cmp_i` and `code_ready_i` have no effect, and the bank keeps its contents.
- R11: A reset in the middle of a pass clears the bank and restarts the sequence at the positive branch, capacitor index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high; a pass starts when it is released |
| cmp_i | input | 1 | Comparator decision |
| msb_ctl_p_o | output | 14 | High-order plate controls, positive branch, 2 bits per capacitor |
| msb_ctl_n_o | output | 14 | High-order plate controls, negative branch |
| lsb_ctl_p_o | output | 12 | Low-order plate controls, positive branch |
| lsb_ctl_n_o | output | 12 | Low-order plate controls, negative branch |
| top_rst_p_o | output | 1 | Ties the positive top plate to common-mode during its sample cycle |
| top_rst_n_o | output | 1 | Ties the negative top plate to common-mode during its sample cycle |
| cal_active_o | output | 1 | High for the whole calibration pass; the analog input stays disconnected while high |
| cal_done_o | output | 1 | One-cycle end-of-calibration strobe |
| code_valid_o | output | 1 | Stream valid for a result |
| code_ready_i | input | 1 | Stream ready from the consumer |
| code_data_o | output | 6 | Stream result code |
| code_branch_o | output | 1 | Stream tag: 0 positive, 1 negative |
| code_cap_o | output | 3 | Stream tag: capacitor index, 0 is largest |
| rd_branch_i | input | 1 | Bank read branch select |
| rd_cap_i | input | 3 | Bank read capacitor select |
| rd_code_o | output | 6 | Bank read data |

## Verification
A wrong sequencer state shows up at the plate controls right away. A step counter that is off by one moves the valid rise, so a low-order field receives the wrong decision within one cycle. A wrong capacitor index shifts the reference slot in the high-order pattern in the cycle after sampling, and it also corrupts the stream tags. A wrong branch register shows up as inverted codes or as controls on the wrong branch during that same measurement. A bank write slip only appears at the read port after the pass, so every entry is read back and compared against the codes the comparator was driven to produce.

// File: rtl/calseq_pkg.sv
package calseq_pkg;

  // bottom-plate control encoding
  typedef enum logic [1:0] {
    PLATE_CM  = 2'b00,
    PLATE_GND = 2'b01,
    PLATE_REF = 2'b10
  } plate_e;

  typedef enum logic [2:0] {
    ST_SAMPLE = 3'd0,
    ST_SETTLE = 3'd1,
    ST_SAR    = 3'd2,
    ST_OFFER  = 3'd3,
    ST_FINISH = 3'd4,
    ST_CONV   = 3'd5
  } seq_state_e;

  localparam int unsigned PLATE_W = 2;
  localparam int unsigned NUM_BRANCH = 2;

endpackage

// File: rtl/calseq_ctrl.sv
module calseq_ctrl
  import calseq_pkg::*;
#(
  parameter int unsigned NUM_MSB  = 7,
  parameter int unsigned SAR_BITS = 6,
  localparam int unsigned CAP_W   = $clog2(NUM_MSB),
  localparam int unsigned STEP_W  = $clog2(SAR_BITS)
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              xfer_i,
  output seq_state_e        state_o,
  output logic              branch_o,
  output logic [CAP_W-1:0]  cap_o,
  output logic [STEP_W-1:0] step_o
);

  localparam logic [CAP_W-1:0]  CAP_LAST  = CAP_W'(NUM_MSB - 1);
  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(SAR_BITS - 1);

  seq_state_e        state_q;
  logic              branch_q;
  logic [CAP_W-1:0]  cap_q;
  logic [STEP_W-1:0] step_q;
  logic              last_meas;

  assign last_meas = branch_q && (cap_q == CAP_LAST);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q  <= ST_SAMPLE;
      branch_q <= 1'b0;
      cap_q    <= '0;
      step_q   <= '0;
    end else begin
      case (state_q)
        ST_SAMPLE: state_q <= ST_SETTLE;
        ST_SETTLE: begin
          state_q <= ST_SAR;
          step_q  <= '0;
        end
        ST_SAR: begin
          if (step_q == STEP_LAST) state_q <= ST_OFFER;
          else                     step_q  <= step_q + 1'b1;
        end
        ST_OFFER: begin
          if (xfer_i) begin
            if (last_meas) begin
              state_q <= ST_FINISH;
            end else begin
              state_q <= ST_SAMPLE;
              if (cap_q == CAP_LAST) begin
                cap_q    <= '0;
                branch_q <= 1'b1;
              end else begin
                cap_q <= cap_q + 1'b1;
              end
            end
          end
        end
        ST_FINISH: state_q <= ST_CONV;
        default:   state_q <= ST_CONV;
      endcase
    end
  end

  assign state_o  = state_q;
  assign branch_o = branch_q;
  assign cap_o    = cap_q;
  assign step_o   = step_q;

endmodule

// File: rtl/calseq_sar.sv
module calseq_sar
  import calseq_pkg::*;
#(
  parameter int unsigned SAR_BITS = 6,
  localparam int unsigned STEP_W  = $clog2(SAR_BITS)
) (
  input  logic                        clk_i,
  input  logic                        rst_i,
  input  logic                        clear_i,
  input  logic                        decide_i,
  input  logic [STEP_W-1:0]           step_i,
  input  logic                        bit_i,
  output logic [SAR_BITS-1:0]         code_o,
  output logic [PLATE_W*SAR_BITS-1:0] ctl_o
);

  logic [SAR_BITS-1:0]         code_q;
  logic [PLATE_W*SAR_BITS-1:0] ctl_q;

  // decision k lands in bit SAR_BITS-1-k, MSB first
  always_ff @(posedge clk_i) begin
    if (rst_i || clear_i) begin
      code_q <= '0;
      ctl_q  <= '0;
    end else if (decide_i) begin
      for (int i = 0; i < SAR_BITS; i++) begin
        if (step_i == STEP_W'(SAR_BITS - 1 - i)) begin
          code_q[i]                  <= bit_i;
          ctl_q[PLATE_W*i +: PLATE_W] <= bit_i ? PLATE_GND : PLATE_REF;
        end
      end
    end
  end

  assign code_o = code_q;
  assign ctl_o  = ctl_q;

endmodule

// File: rtl/calseq_steer.sv
module calseq_steer
  import calseq_pkg::*;
#(
  parameter int unsigned NUM_MSB  = 7,
  parameter int unsigned SAR_BITS = 6,
  localparam int unsigned CAP_W   = $clog2(NUM_MSB),
  localparam int unsigned MSB_W   = PLATE_W * NUM_MSB,
  localparam int unsigned LSB_W   = PLATE_W * SAR_BITS
) (
  input  seq_state_e       state_i,
  input  logic             branch_i,
  input  logic [CAP_W-1:0] cap_i,
  input  logic [LSB_W-1:0] sar_ctl_i,
  output logic [MSB_W-1:0] msb_p_o,
  output logic [MSB_W-1:0] msb_n_o,
  output logic [LSB_W-1:0] lsb_p_o,
  output logic [LSB_W-1:0] lsb_n_o,
  output logic             tie_p_o,
  output logic             tie_n_o
);

  logic             pattern_on;
  logic [MSB_W-1:0] msb_pat;
  logic [LSB_W-1:0] lsb_pat;
  int unsigned      slot;

  assign pattern_on = (state_i == ST_SETTLE) || (state_i == ST_SAR) ||
                      (state_i == ST_OFFER);

  // slot 0 is the smallest high-order capacitor
  always_comb begin
    slot    = NUM_MSB - 1 - 32'(cap_i);
    msb_pat = '0;
    if (pattern_on) begin
      for (int unsigned m = 0; m < NUM_MSB; m++) begin
        if (m == slot)     msb_pat[PLATE_W*m +: PLATE_W] = PLATE_REF;
        else if (m < slot) msb_pat[PLATE_W*m +: PLATE_W] = PLATE_GND;
      end
    end
    lsb_pat = pattern_on ? sar_ctl_i : '0;
  end

  assign msb_p_o = branch_i ? '0 : msb_pat;
  assign msb_n_o = branch_i ? msb_pat : '0;
  assign lsb_p_o = branch_i ? '0 : lsb_pat;
  assign lsb_n_o = branch_i ? lsb_pat : '0;
  assign tie_p_o = (state_i == ST_SAMPLE) && !branch_i;
  assign tie_n_o = (state_i == ST_SAMPLE) && branch_i;

endmodule

// File: rtl/calseq_bank.sv
module calseq_bank
  import calseq_pkg::*;
#(
  parameter int unsigned NUM_MSB  = 7,
  parameter int unsigned SAR_BITS = 6,
  localparam int unsigned CAP_W   = $clog2(NUM_MSB)
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                we_i,
  input  logic                wr_branch_i,
  input  logic [CAP_W-1:0]    wr_cap_i,
  input  logic [SAR_BITS-1:0] wr_code_i,
  input  logic                rd_branch_i,
  input  logic [CAP_W-1:0]    rd_cap_i,
  output logic [SAR_BITS-1:0] rd_code_o
);

  logic [SAR_BITS-1:0] mem_q [NUM_BRANCH][NUM_MSB];

  for (genvar gb = 0; gb < NUM_BRANCH; gb++) begin : g_branch
    for (genvar gc = 0; gc < NUM_MSB; gc++) begin : g_cap
      always_ff @(posedge clk_i) begin
        if (rst_i)
          mem_q[gb][gc] <= '0;
        else if (we_i && (wr_branch_i == 1'(gb)) && (wr_cap_i == CAP_W'(gc)))
          mem_q[gb][gc] <= wr_code_i;
      end
    end
  end

  always_comb begin
    rd_code_o = '0;
    for (int b = 0; b < NUM_BRANCH; b++) begin
      for (int c = 0; c < NUM_MSB; c++) begin
        if ((rd_branch_i == 1'(b)) && (rd_cap_i == CAP_W'(c)))
          rd_code_o = mem_q[b][c];
      end
    end
  end

endmodule

// File: rtl/cal_mismatch_seq.sv
module cal_mismatch_seq
  import calseq_pkg::*;
#(
  parameter int unsigned NUM_MSB  = 7,
  parameter int unsigned SAR_BITS = 6,
  localparam int unsigned CAP_W   = $clog2(NUM_MSB),
  localparam int unsigned STEP_W  = $clog2(SAR_BITS),
  localparam int unsigned MSB_W   = PLATE_W * NUM_MSB,
  localparam int unsigned LSB_W   = PLATE_W * SAR_BITS
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                cmp_i,
  output logic [MSB_W-1:0]    msb_ctl_p_o,
  output logic [MSB_W-1:0]    msb_ctl_n_o,
  output logic [LSB_W-1:0]    lsb_ctl_p_o,
  output logic [LSB_W-1:0]    lsb_ctl_n_o,
  output logic                top_rst_p_o,
  output logic                top_rst_n_o,
  output logic                cal_active_o,
  output logic                cal_done_o,
  output logic                code_valid_o,
  input  logic                code_ready_i,
  output logic [SAR_BITS-1:0] code_data_o,
  output logic                code_branch_o,
  output logic [CAP_W-1:0]    code_cap_o,
  input  logic                rd_branch_i,
  input  logic [CAP_W-1:0]    rd_cap_i,
  output logic [SAR_BITS-1:0] rd_code_o
);

  seq_state_e          state;
  logic                branch;
  logic [CAP_W-1:0]    cap;
  logic [STEP_W-1:0]   step;
  logic                xfer;
  logic                bit_eff;
  logic [SAR_BITS-1:0] sar_code;
  logic [LSB_W-1:0]    sar_ctl;

  assign code_valid_o = (state == ST_OFFER);
  assign xfer         = code_valid_o && code_ready_i;
  // negative branch sits on the other comparator input
  assign bit_eff      = cmp_i ^ branch;

  calseq_ctrl #(.NUM_MSB(NUM_MSB), .SAR_BITS(SAR_BITS)) ctrl_i (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .xfer_i   (xfer),
    .state_o  (state),
    .branch_o (branch),
    .cap_o    (cap),
    .step_o   (step)
  );

  calseq_sar #(.SAR_BITS(SAR_BITS)) sar_i (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .clear_i  (state == ST_SAMPLE),
    .decide_i (state == ST_SAR),
    .step_i   (step),
    .bit_i    (bit_eff),
    .code_o   (sar_code),
    .ctl_o    (sar_ctl)
  );

  calseq_steer #(.NUM_MSB(NUM_MSB), .SAR_BITS(SAR_BITS)) steer_i (
    .state_i   (state),
    .branch_i  (branch),
    .cap_i     (cap),
    .sar_ctl_i (sar_ctl),
    .msb_p_o   (msb_ctl_p_o),
    .msb_n_o   (msb_ctl_n_o),
    .lsb_p_o   (lsb_ctl_p_o),
    .lsb_n_o   (lsb_ctl_n_o),
    .tie_p_o   (top_rst_p_o),
    .tie_n_o   (top_rst_n_o)
  );

  calseq_bank #(.NUM_MSB(NUM_MSB), .SAR_BITS(SAR_BITS)) bank_i (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .we_i        (xfer),
    .wr_branch_i (branch),
    .wr_cap_i    (cap),
    .wr_code_i   (sar_code),
    .rd_branch_i (rd_branch_i),
    .rd_cap_i    (rd_cap_i),
    .rd_code_o   (rd_code_o)
  );

  assign cal_active_o  = (state != ST_CONV);
  assign cal_done_o    = (state == ST_FINISH);
  assign code_data_o   = sar_code;
  assign code_branch_o = branch;
  assign code_cap_o    = cap;

endmodule

// File: rtl/calseq_chk.sv
module calseq_chk #(
  parameter int unsigned NUM_MSB  = 7,
  parameter int unsigned SAR_BITS = 6,
  localparam int unsigned CAP_W   = $clog2(NUM_MSB)
) (
  input logic                  clk_i,
  input logic                  rst_i,
  input logic [2*NUM_MSB-1:0]  msb_ctl_p_o,
  input logic [2*NUM_MSB-1:0]  msb_ctl_n_o,
  input logic [2*SAR_BITS-1:0] lsb_ctl_p_o,
  input logic [2*SAR_BITS-1:0] lsb_ctl_n_o,
  input logic                  top_rst_p_o,
  input logic                  top_rst_n_o,
  input logic                  cal_active_o,
  input logic                  cal_done_o,
  input logic                  code_valid_o,
  input logic                  code_ready_i,
  input logic [SAR_BITS-1:0]   code_data_o,
  input logic                  code_branch_o,
  input logic [CAP_W-1:0]      code_cap_o
);

  // R3: sample cycle leaves every bottom plate at common-mode
  a_r3_sample_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
    (top_rst_p_o || top_rst_n_o) |-> (msb_ctl_p_o == '0 && msb_ctl_n_o == '0 &&
                                      lsb_ctl_p_o == '0 && lsb_ctl_n_o == '0));

  // R3: never both top plates tied at once
  a_r3_single_tie: assert property (@(posedge clk_i) disable iff (rst_i)
    !(top_rst_p_o && top_rst_n_o));

  // R4: only the branch under test drives its plates
  a_r4_one_branch: assert property (@(posedge clk_i) disable iff (rst_i)
    (msb_ctl_p_o != '0) |-> (msb_ctl_n_o == '0 && lsb_ctl_n_o == '0));

  // R7: stalled stream holds valid and payload
  a_r7_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    (code_valid_o && !code_ready_i) |=> (code_valid_o && $stable(code_data_o) &&
                                         $stable(code_cap_o) && $stable(code_branch_o)));

  // R9: end strobe lasts one cycle and closes the pass
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
    cal_done_o |=> (!cal_done_o && !cal_active_o));

  // R10: idle after calibration
  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
    !cal_active_o |-> (!code_valid_o && !top_rst_p_o && !top_rst_n_o &&
                       msb_ctl_p_o == '0 && msb_ctl_n_o == '0));

endmodule

bind cal_mismatch_seq calseq_chk #(.NUM_MSB(NUM_MSB), .SAR_BITS(SAR_BITS)) chk_i (
  .clk_i         (clk_i),
  .rst_i         (rst_i),
  .msb_ctl_p_o   (msb_ctl_p_o),
  .msb_ctl_n_o   (msb_ctl_n_o),
  .lsb_ctl_p_o   (lsb_ctl_p_o),
  .lsb_ctl_n_o   (lsb_ctl_n_o),
  .top_rst_p_o   (top_rst_p_o),
  .top_rst_n_o   (top_rst_n_o),
  .cal_active_o  (cal_active_o),
  .cal_done_o    (cal_done_o),
  .code_valid_o  (code_valid_o),
  .code_ready_i  (code_ready_i),
  .code_data_o   (code_data_o),
  .code_branch_o (code_branch_o),
  .code_cap_o    (code_cap_o)
);

// File: tb/cal_mismatch_seq_tb_top.sv
module cal_mismatch_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst, cmp, ready, rd_branch;
  logic [2:0]  rd_cap;
  logic [13:0] msb_p, msb_n;
  logic [11:0] lsb_p, lsb_n;
  logic        tie_p, tie_n, active, done, valid, c_branch;
  logic [5:0]  c_data, rd_code;
  logic [2:0]  c_cap;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [9:0] exp_q[$];

  always #10 clk = ~clk;

  cal_mismatch_seq dut_i (
    .clk_i(clk), .rst_i(rst), .cmp_i(cmp),
    .msb_ctl_p_o(msb_p), .msb_ctl_n_o(msb_n),
    .lsb_ctl_p_o(lsb_p), .lsb_ctl_n_o(lsb_n),
    .top_rst_p_o(tie_p), .top_rst_n_o(tie_n),
    .cal_active_o(active), .cal_done_o(done),
    .code_valid_o(valid), .code_ready_i(ready),
    .code_data_o(c_data), .code_branch_o(c_branch), .code_cap_o(c_cap),
    .rd_branch_i(rd_branch), .rd_cap_i(rd_cap), .rd_code_o(rd_code)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  function automatic logic [5:0] exp_code(int b, int k, int pass);
    if (pass == 0 && b == 0 && k == 0) return 6'h3F;
    if (pass == 0 && b == 1 && k == 6) return 6'h00;
    return 6'((b * 23 + k * 11 + 5 + pass * 17) & 63);
  endfunction

  function automatic logic [13:0] exp_msb(int k);
    logic [13:0] v = '0;
    for (int m = 0; m < 7; m++) begin
      if (m == 6 - k)     v[2*m +: 2] = 2'b10;
      else if (m < 6 - k) v[2*m +: 2] = 2'b01;
    end
    return v;
  endfunction

  function automatic logic [11:0] exp_lsb(logic [5:0] code, int lowest);
    logic [11:0] v = '0;
    for (int i = 0; i < 6; i++)
      if (i >= lowest) v[2*i +: 2] = code[i] ? 2'b01 : 2'b10;
    return v;
  endfunction

  // monitor: compares each handshake with the scoreboard
  always @(negedge clk) begin
    if (!rst && valid && ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 unexpected result", {22'b0, c_branch, c_cap, c_data}, 0);
      end else begin
        logic [9:0] e;
        e = exp_q.pop_front();
        chk({c_branch, c_cap, c_data} == e, "R2/R6 stream item order and code",
            {22'b0, c_branch, c_cap, c_data}, {22'b0, e});
      end
    end
  end

  // one measurement, entered in its sample cycle
  task automatic run_meas(int b, int k, int pass, int stall);
    logic [5:0]  code = exp_code(b, k, pass);
    logic [13:0] pm, pn;
    logic [11:0] lm, ln;
    chk(tie_p == (b == 0) && tie_n == (b == 1), "R3 top-plate tie in sample",
        {tie_p, tie_n}, {b == 0, b == 1});
    chk(msb_p == 0 && msb_n == 0 && lsb_p == 0 && lsb_n == 0 && !valid,
        "R3 all common-mode in sample", {msb_p, lsb_p}, 0);
    step();
    pm = (b == 0) ? exp_msb(k) : 14'h0;
    pn = (b == 1) ? exp_msb(k) : 14'h0;
    chk(msb_p == pm && msb_n == pn, "R4 high-order pattern", {msb_p, msb_n}, {pm, pn});
    for (int t = 0; t < 6; t++) begin
      step();
      cmp = code[5 - t] ^ b[0];
      if (t == 3) begin
        lm = (b == 0) ? exp_lsb(code, 3) : 12'h0;
        ln = (b == 1) ? exp_lsb(code, 3) : 12'h0;
        chk(lsb_p == lm && lsb_n == ln, "R5 partial low-order controls",
            {lsb_p, lsb_n}, {lm, ln});
      end
    end
    step();
    cmp = ~cmp;
    lm = (b == 0) ? exp_lsb(code, 0) : 12'h0;
    ln = (b == 1) ? exp_lsb(code, 0) : 12'h0;
    chk(valid == 1'b1, "R7 valid after sixth decision", valid, 1);
    chk(lsb_p == lm && lsb_n == ln, "R5 final low-order controls",
        {lsb_p, lsb_n}, {lm, ln});
    for (int s = 0; s < stall; s++) begin
      step();
      chk(valid && c_data == code && msb_p == pm && msb_n == pn,
          "R7 stall holds stream and plates", {valid, c_data}, {1'b1, code});
    end
    exp_q.push_back({b[0], 3'(k), code});
    ready = 1'b1;
    step();
    ready = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cmp = 1'b0; ready = 1'b0; rd_branch = 1'b0; rd_cap = 3'd0;
    repeat (3) step();
    chk(active && tie_p && !tie_n && !valid && !done, "R1 reset outputs",
        {active, tie_p, tie_n, valid, done}, 5'b11000);
    for (int b = 0; b < 2; b++)
      for (int k = 0; k < 7; k++) begin
        rd_branch = b[0]; rd_cap = 3'(k); #1;
        chk(rd_code == 0, "R1 bank clear at reset", rd_code, 0);
      end
    rst = 1'b0;
    chk(active && tie_p, "R1 pass starts after release", {active, tie_p}, 2'b11);

    for (int b = 0; b < 2; b++)
      for (int k = 0; k < 7; k++)
        run_meas(b, k, 0, (k == 2 || (b == 1 && k == 5)) ? 3 : 0);

    chk(done && active, "R9 end strobe with active still high", {done, active}, 2'b11);
    step();
    chk(!done && !active, "R9 strobe single cycle and active drops", {done, active}, 2'b00);
    ready = 1'b1;
    for (int i = 0; i < 4; i++) begin
      cmp = i[0];
      step();
      chk(!valid && !tie_p && !tie_n && msb_p == 0 && msb_n == 0 &&
          lsb_p == 0 && lsb_n == 0 && !done,
          "R10 idle after pass ignores inputs", {valid, msb_p, lsb_p}, 0);
    end
    ready = 1'b0;
    chk(exp_q.size() == 0, "R2 all fourteen results seen", exp_q.size(), 0);
    for (int b = 0; b < 2; b++)
      for (int k = 0; k < 7; k++) begin
        rd_branch = b[0]; rd_cap = 3'(k); #1;
        chk(rd_code == exp_code(b, k, 0), "R8 bank contents", rd_code, exp_code(b, k, 0));
      end

    // second pass, reset part way through
    rst = 1'b1; step(); rst = 1'b0;
    run_meas(0, 0, 1, 0);
    run_meas(0, 1, 1, 1);
    rd_branch = 1'b0; rd_cap = 3'd1; #1;
    chk(rd_code == exp_code(0, 1, 1), "R8 bank written on handshake", rd_code, exp_code(0, 1, 1));
    step(); step();
    rst = 1'b1;
    step();
    rst = 1'b0;
    for (int k = 0; k < 2; k++) begin
      rd_branch = 1'b0; rd_cap = 3'(k); #1;
      chk(rd_code == 0, "R11 bank cleared by mid-pass reset", rd_code, 0);
    end
    run_meas(0, 0, 2, 0);
    chk(exp_q.size() == 0, "R11 restart tagged branch 0 index 0", exp_q.size(), 0);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule